// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block decides which clock a small processor core runs on and puts the core to sleep or wakes it. A 16-bit configuration word, written through a plain write strobe, holds the PLL multiplier and the clock-source choices. It also holds the stop-depth choice and the wake-up pin and level settings. The analog oscillator and VCO are outside the block. It only drives their enables and the multiplier value, and it flags a multiplier that lies outside the lock range.

All clock dividers are modelled as single-cycle enable pulses on one fast clock `clk`. The input `vco_tick` marks one VCO period. The input `xtal_tick` is the always-on reference at twice the crystal rate, so every second pulse of it is one 32 kHz crystal period, called a slow tick below. The output `sys_clk_en` marks each cycle in which the core may advance.

A one-cycle `stop_req` from the core gates `sys_clk_en` until a selected wake-up pin, seen through a two-stage slow-tick synchronizer, reaches the selected level. The stop depth is fixed at the moment of entry:
- With the oscillator left running (warm stop), wake-up gives a one-cycle `resume_pulse` and the core continues at the next instruction.
- With the oscillator stopped (cold stop), wake-up raises `restart_req` for a settle window before the core is released, the same sequence as after power-on reset.

Top module: `lpc_clock_ctrl`

## Requirements
- R1: Configuration word layout: bit 0 stop-osc, bit 1 stop-VCO, bit 2 bypass, bits 4:3 clock select, bits 6:5 wake select, bit 7 wake level, bits 15:8 multiplier N. Reset loads 0x6400 (N=100, all other fields 0). After reset `restart_req` is 1 and `sys_clk_en` is 0 until SETTLE_CYC slow ticks have passed.
- R2: `pll_mult` equals bits 15:8. `mult_bad` is 1 exactly when N <= 39 or N >= 158.
- R3: With bypass 0, clock select gives the following `sys_clk_en` rates:

  | Select | Rate |
  |---|---|
  | 00 | every VCO tick |
  | 01 | every second VCO tick |
  | 10 | every fourth VCO tick |
  | 11 | every `xtal_tick` (twice crystal) |

- R4: With bypass 1, `sys_clk_en` pulses on every slow tick (every second `xtal_tick`), whatever the clock select holds.
- R5: Outside a cold stop, `vco_en` is the inverse of the stop-VCO bit. While `vco_en` is 0, the VCO-derived selections give no `sys_clk_en`. The bypass (slow) clock is not affected.
- R6: A `stop_req` while the core is running raises `stopped` at the next clock edge. While `stopped` or `restart_req` is 1, `sys_clk_en` stays 0.
- R7: Wake select 00 allows no pin wake-up, so only `rst_n` ends the stop. Select 01 uses `wake_pins[0]`, 10 uses `wake_pins[1]`, and 11 uses any of `wake_pins[2:0]`. A pin wakes the block when it equals the wake level bit.
- R8: Warm stop (stop-osc 0 at entry) keeps `osc_en` at 1. On wake, `stopped` falls, `resume_pulse` is 1 for exactly the first running cycle, and `restart_req` stays 0.
- R9: Cold stop (stop-osc 1 at entry) drives `osc_en` and `vco_en` to 0 while stopped. On wake, `restart_req` rises as `stopped` falls and holds for SETTLE_CYC slow ticks, with no `resume_pulse`. The block then runs with `osc_en` at 1.
- R10: A register write in the same cycle as `stop_req` does not change the stop depth; the depth comes from the word held before that write.
- R11: Wake pins pass through two slow-tick synchronizer stages. Pins not selected, or selected pins at the other level, leave the block stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock, all state is on this edge |
| rst_n | input | 1 | active-low power-on reset |
| wr_en | input | 1 | write strobe for the configuration word |
| wr_data | input | 16 | configuration word to write |
| stop_req | input | 1 | one-cycle stop request from the core |
| vco_tick | input | 1 | one pulse per VCO period |
| xtal_tick | input | 1 | always-on reference, twice the crystal rate |
| wake_pins | input | 3 | candidate wake-up pins |
| osc_en | output | 1 | oscillator enable |
| vco_en | output | 1 | VCO enable |
| pll_mult | output | 8 | PLL multiplier N |
| mult_bad | output | 1 | N outside the lock range |
| sys_clk_en | output | 1 | core clock enable pulse |
| stopped | output | 1 | core clock gated, waiting for wake-up |
| restart_req | output | 1 | core held for restart from the reset vector |
| resume_pulse | output | 1 | warm wake, continue at the next instruction |

## Verification
A register write and a stop request can arrive in the same cycle. That cycle decides both the new configuration word and the stop depth. The bench provokes this by driving `wr_en` with a word that sets stop-osc on the very edge where `stop_req` is sampled, while the held word has stop-osc clear. The result is judged at the ports: `osc_en` must stay 1 during the stop, and the wake-up must produce `resume_pulse` rather than `restart_req`.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  localparam int CFG_W     = 16;
  localparam int MULT_W    = 8;
  localparam int WAKE_PINS = 3;

  // Field order is the bit layout of the configuration word, MSB first.
  typedef struct packed {
    logic [MULT_W-1:0] mult;
    logic              wake_lvl;
    logic [1:0]        wake_sel;
    logic [1:0]        clk_sel;
    logic              bypass;
    logic              stop_vco;
    logic              stop_osc;
  } lpc_cfg_t;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2
  } lpc_state_e;

  localparam logic [1:0] CSEL_VCO    = 2'd0;
  localparam logic [1:0] CSEL_VCO_D2 = 2'd1;
  localparam logic [1:0] CSEL_VCO_D4 = 2'd2;
  localparam logic [1:0] CSEL_XTALX2 = 2'd3;

endpackage

// File: rtl/lpc_cfg_reg.sv
module lpc_cfg_reg
  import lpc_pkg::*;
#(
  parameter int RESET_MULT = 100,
  parameter int MULT_MIN   = 39,
  parameter int MULT_MAX   = 158
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output lpc_cfg_t         cfg,
  output logic             mult_bad
);

  localparam logic [CFG_W-1:0] RESET_WORD =
    {MULT_W'(RESET_MULT), {(CFG_W-MULT_W){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= lpc_cfg_t'(RESET_WORD);
    end else if (wr_en) begin
      cfg <= lpc_cfg_t'(wr_data);
    end
  end

  // The valid range is open at both ends.
  assign mult_bad = (cfg.mult <= MULT_W'(MULT_MIN)) ||
                    (cfg.mult >= MULT_W'(MULT_MAX));

endmodule

// File: rtl/lpc_clk_gen.sv
module lpc_clk_gen
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vco_tick,
  input  logic       xtal_tick,
  input  logic       vco_en,
  input  logic       osc_en,
  input  logic       bypass,
  input  logic [1:0] clk_sel,
  input  logic       hold,
  output logic       sys_clk_en,
  output logic       slow_tick
);

  localparam int VDIV_W = 2;          // deepest VCO divide is 2**VDIV_W
  localparam int NTAP   = VDIV_W + 1;

  logic [VDIV_W-1:0] vdiv;
  logic              xtog;
  logic [NTAP-1:0]   vtap;
  logic              src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vdiv <= '0;
      xtog <= 1'b0;
    end else begin
      if (vco_tick)  vdiv <= vdiv + 1'b1;
      if (xtal_tick) xtog <= ~xtog;
    end
  end

  // tap g pulses on one VCO tick in every 2**g
  genvar g;
  generate
    for (g = 0; g < NTAP; g++) begin : g_tap
      if (g == 0) begin : g_full
        assign vtap[g] = vco_tick;
      end else begin : g_div
        assign vtap[g] = vco_tick & (&vdiv[g-1:0]);
      end
    end
  endgenerate

  assign slow_tick = xtal_tick & xtog;

  always_comb begin
    src = 1'b0;
    if (bypass) begin
      src = slow_tick & osc_en;
    end else begin
      case (clk_sel)
        CSEL_VCO:    src = vtap[0] & vco_en;
        CSEL_VCO_D2: src = vtap[1] & vco_en;
        CSEL_VCO_D4: src = vtap[2] & vco_en;
        default:     src = xtal_tick & osc_en;
      endcase
    end
  end

  assign sys_clk_en = src & ~hold;

endmodule

// File: rtl/lpc_wake_sync.sv
module lpc_wake_sync
  import lpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slow_tick,
  input  logic [WAKE_PINS-1:0] pins,
  input  logic [1:0]           wake_sel,
  input  logic                 wake_lvl,
  output logic                 wake_hit
);

  logic [SYNC_STAGES-1:0][WAKE_PINS-1:0] sr;
  logic [WAKE_PINS-1:0]                  mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (slow_tick) begin
      sr <= {sr[SYNC_STAGES-2:0], pins};
    end
  end

  always_comb begin
    case (wake_sel)
      2'd1:    mask = 3'b001;
      2'd2:    mask = 3'b010;
      2'd3:    mask = 3'b111;
      default: mask = 3'b000;
    endcase
  end

  assign wake_hit =
    |(mask & ~(sr[SYNC_STAGES-1] ^ {WAKE_PINS{wake_lvl}}));

endmodule

// File: rtl/lpc_stop_fsm.sv
module lpc_stop_fsm
  import lpc_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic slow_tick,
  input  logic wake_hit,
  input  logic stop_osc_cfg,
  output logic stopped,
  output logic cold,
  output logic restart_req,
  output logic resume_pulse
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  lpc_state_e       state;
  logic [CNT_W-1:0] cnt;

  // Power-on behaves like a cold restart.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_SETTLE;
      cnt          <= '0;
      cold         <= 1'b0;
      resume_pulse <= 1'b0;
    end else begin
      resume_pulse <= 1'b0;
      case (state)
        ST_RUN: begin
          if (stop_req) begin
            state <= ST_STOP;
            cold  <= stop_osc_cfg;
          end
        end
        ST_STOP: begin
          if (slow_tick && wake_hit) begin
            if (cold) begin
              state <= ST_SETTLE;
              cnt   <= '0;
            end else begin
              state        <= ST_RUN;
              resume_pulse <= 1'b1;
            end
          end
        end
        default: begin
          if (slow_tick) begin
            if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
              state <= ST_RUN;
              cnt   <= '0;
              cold  <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign stopped     = (state == ST_STOP);
  assign restart_req = (state == ST_SETTLE);

endmodule

// File: rtl/lpc_clock_ctrl.sv
module lpc_clock_ctrl
  import lpc_pkg::*;
#(
  parameter int RESET_MULT  = 100,
  parameter int MULT_MIN    = 39,
  parameter int MULT_MAX    = 158,
  parameter int SETTLE_CYC  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              stop_req,
  input  logic              vco_tick,
  input  logic              xtal_tick,
  input  logic [2:0]        wake_pins,
  output logic              osc_en,
  output logic              vco_en,
  output logic [7:0]        pll_mult,
  output logic              mult_bad,
  output logic              sys_clk_en,
  output logic              stopped,
  output logic              restart_req,
  output logic              resume_pulse
);

  lpc_cfg_t cfg;
  logic     slow_tick;
  logic     wake_hit;
  logic     cold;

  lpc_cfg_reg #(
    .RESET_MULT(RESET_MULT),
    .MULT_MIN  (MULT_MIN),
    .MULT_MAX  (MULT_MAX)
  ) i_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg     (cfg),
    .mult_bad(mult_bad)
  );

  lpc_clk_gen i_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vco_tick  (vco_tick),
    .xtal_tick (xtal_tick),
    .vco_en    (vco_en),
    .osc_en    (osc_en),
    .bypass    (cfg.bypass),
    .clk_sel   (cfg.clk_sel),
    .hold      (stopped | restart_req),
    .sys_clk_en(sys_clk_en),
    .slow_tick (slow_tick)
  );

  lpc_wake_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .pins     (wake_pins),
    .wake_sel (cfg.wake_sel),
    .wake_lvl (cfg.wake_lvl),
    .wake_hit (wake_hit)
  );

  lpc_stop_fsm #(
    .SETTLE_CYC(SETTLE_CYC)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .slow_tick   (slow_tick),
    .wake_hit    (wake_hit),
    .stop_osc_cfg(cfg.stop_osc),
    .stopped     (stopped),
    .cold        (cold),
    .restart_req (restart_req),
    .resume_pulse(resume_pulse)
  );

  assign osc_en   = ~(stopped & cold);
  assign vco_en   = ~cfg.stop_vco & osc_en;
  assign pll_mult = cfg.mult;

endmodule

// File: rtl/lpc_clock_ctrl_chk.sv
module lpc_clock_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_req,
  input logic osc_en,
  input logic sys_clk_en,
  input logic stopped,
  input logic restart_req,
  input logic resume_pulse
);

  assert_no_clk_when_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped || restart_req) |-> !sys_clk_en);

  assert_stop_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_req) && !$past(stopped) && !$past(restart_req)) |-> stopped);

  assert_states_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(stopped && restart_req));

  assert_resume_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  assert_resume_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> ($past(stopped) && !stopped && !restart_req));

  assert_osc_off_only_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> stopped);

  assert_cold_wake_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stopped) && !stopped && !$past(osc_en)) |-> (restart_req && !resume_pulse));

endmodule

bind lpc_clock_ctrl lpc_clock_ctrl_chk i_lpc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_req    (stop_req),
  .osc_en      (osc_en),
  .sys_clk_en  (sys_clk_en),
  .stopped     (stopped),
  .restart_req (restart_req),
  .resume_pulse(resume_pulse)
);

// File: tb/test_lpc_clock_ctrl.sv
`timescale 1ns/1ps
module test_lpc_clock_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic        stop_req = 1'b0;
  logic        vco_tick = 1'b0;
  logic        xtal_tick = 1'b0;
  logic [2:0]  wake_pins = 3'b000;
  logic        osc_en, vco_en, mult_bad, sys_clk_en, stopped, restart_req, resume_pulse;
  logic [7:0]  pll_mult;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam int SETTLE = 16;

  lpc_clock_ctrl #(.SETTLE_CYC(SETTLE)) i_lpc_clock_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stop_req(stop_req), .vco_tick(vco_tick), .xtal_tick(xtal_tick),
    .wake_pins(wake_pins), .osc_en(osc_en), .vco_en(vco_en),
    .pll_mult(pll_mult), .mult_bad(mult_bad), .sys_clk_en(sys_clk_en),
    .stopped(stopped), .restart_req(restart_req), .resume_pulse(resume_pulse)
  );

  always #2 clk = ~clk;   // 250 MHz

  // VCO tick every cycle, xtal_tick every fourth cycle (slow tick every eighth)
  always @(posedge clk) begin
    #1;
    cyc++;
    vco_tick  = 1'b1;
    xtal_tick = (cyc % 4 == 0);
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic logic [15:0] mk(int n, bit lvl, int wsel, int csel,
                                     bit byp, bit svco, bit sosc);
    return {n[7:0], lvl, wsel[1:0], csel[1:0], byp, svco, sosc};
  endfunction

  task automatic write_cfg(logic [15:0] d);
    @(posedge clk); #1; wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_en(int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (sys_clk_en) c++;
    end
  endtask

  task automatic do_stop();
    @(posedge clk); #1; stop_req = 1'b1;
    @(posedge clk); #1; stop_req = 1'b0;
    @(negedge clk);
  endtask

  // wait at negedges until stopped falls; returns 1 if it did
  task automatic wait_wake(int maxc, output bit woke);
    woke = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (!stopped) begin woke = 1'b1; break; end
    end
  endtask

  task automatic wait_release(int maxc, output bit rel);
    rel = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (!restart_req) begin rel = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    bit rel;
    int c;
    @(negedge clk);
    chk("R1 restart_req after reset", restart_req, 1);
    chk("R1 sys_clk_en after reset", sys_clk_en, 0);
    chk("R1 pll_mult reset", pll_mult, 100);
    chk("R2 mult_bad at N=100", mult_bad, 0);
    chk("R1 osc_en reset", osc_en, 1);
    chk("R1 vco_en reset", vco_en, 1);
    chk("R1 stopped reset", stopped, 0);
    wait_release(400, rel);
    chk("R1 restart released after settle", rel, 1);
    count_en(8, c);
    chk("R1 clock runs after settle", c, 8);
  endtask

  task automatic t_clksel();
    int c;
    int exp[4] = '{40, 20, 10, 10};
    for (int s = 0; s < 4; s++) begin
      write_cfg(mk(100, 0, 0, s, 0, 0, 0));
      count_en(40, c);
      chk($sformatf("R3 clock select %0d", s), c, exp[s]);
    end
  endtask

  task automatic t_bypass();
    int c;
    write_cfg(mk(100, 0, 0, 0, 1, 0, 0));
    count_en(40, c);
    chk("R4 bypass slow clock", c, 5);
    write_cfg(mk(100, 0, 0, 2, 1, 1, 0));
    @(negedge clk);
    chk("R5 vco_en off in slow mode", vco_en, 0);
    count_en(40, c);
    chk("R5 slow clock with VCO stopped", c, 5);
    write_cfg(mk(100, 0, 0, 0, 0, 1, 0));
    count_en(40, c);
    chk("R5 VCO clock gated by stopped VCO", c, 0);
    write_cfg(mk(100, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R5 vco_en back on", vco_en, 1);
  endtask

  task automatic t_mult();
    int ns[4]  = '{39, 40, 157, 158};
    int exp[4] = '{1, 0, 0, 1};
    for (int i = 0; i < 4; i++) begin
      write_cfg(mk(ns[i], 0, 0, 0, 0, 0, 0));
      @(negedge clk);
      chk("R2 pll_mult field", pll_mult, ns[i]);
      chk($sformatf("R2 mult_bad N=%0d", ns[i]), mult_bad, exp[i]);
    end
  endtask

  task automatic t_warm();
    int c;
    bit woke;
    wake_pins = 3'b000;
    write_cfg(mk(100, 1, 1, 0, 0, 0, 0));
    idle(40);
    do_stop();
    chk("R6 stopped after stop_req", stopped, 1);
    chk("R8 osc_en kept in warm stop", osc_en, 1);
    wake_pins = 3'b110;
    count_en(60, c);
    chk("R6 no clock while stopped", c, 0);
    chk("R11 unselected pins ignored", stopped, 1);
    wake_pins = 3'b001;
    wait_wake(80, woke);
    chk("R7 wake on pin0 high", woke, 1);
    chk("R8 resume_pulse on warm wake", resume_pulse, 1);
    chk("R8 no restart on warm wake", restart_req, 0);
    @(negedge clk);
    chk("R8 resume_pulse one cycle", resume_pulse, 0);
  endtask

  task automatic t_cold();
    bit woke;
    int c;
    wake_pins = 3'b111;
    write_cfg(mk(100, 0, 2, 0, 0, 0, 1));
    idle(40);
    do_stop();
    chk("R9 osc_en off in cold stop", osc_en, 0);
    chk("R9 vco_en off in cold stop", vco_en, 0);
    wake_pins = 3'b110;
    idle(60);
    chk("R11 pin0 low ignored with select 10", stopped, 1);
    wake_pins = 3'b101;
    wait_wake(80, woke);
    chk("R7 wake on pin1 low", woke, 1);
    chk("R9 restart_req on cold wake", restart_req, 1);
    chk("R9 no resume_pulse on cold wake", resume_pulse, 0);
    chk("R9 osc_en on during settle", osc_en, 1);
    c = 0;
    while (restart_req && c < 100) begin
      if (xtal_tick) c++;
      @(negedge clk);
    end
    chk_rng("R9 settle length in xtal pulses", c, 2*SETTLE-1, 2*SETTLE+1);
    chk("R9 running after settle", stopped, 0);
    write_cfg(mk(100, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_none();
    bit rel;
    write_cfg(mk(100, 1, 0, 0, 0, 0, 0));
    idle(20);
    do_stop();
    wake_pins = 3'b111;
    idle(50);
    wake_pins = 3'b000;
    idle(50);
    chk("R7 select 00 ignores all pins", stopped, 1);
    @(posedge clk); #1; rst_n = 1'b0;
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset ends stop", stopped, 0);
    chk("R1 restart after reset from stop", restart_req, 1);
    chk("R1 config back to reset value", pll_mult, 100);
    wait_release(400, rel);
    chk("R1 released after reset", rel, 1);
  endtask

  task automatic t_any();
    bit woke;
    wake_pins = 3'b111;
    write_cfg(mk(100, 0, 3, 0, 0, 0, 0));
    idle(40);
    do_stop();
    chk("R6 stopped select 11", stopped, 1);
    wake_pins = 3'b011;
    wait_wake(80, woke);
    chk("R7 wake on pin2 with select 11", woke, 1);
    chk("R8 warm resume select 11", resume_pulse, 1);
  endtask

  task automatic t_coincide();
    bit woke;
    wake_pins = 3'b000;
    write_cfg(mk(100, 1, 1, 0, 0, 0, 0));
    idle(40);
    @(posedge clk); #1;
    stop_req = 1'b1; wr_en = 1'b1; wr_data = mk(100, 1, 1, 0, 0, 0, 1);
    @(posedge clk); #1;
    stop_req = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    chk("R10 stopped on write+stop", stopped, 1);
    chk("R10 depth from old word keeps osc", osc_en, 1);
    wake_pins = 3'b001;
    wait_wake(80, woke);
    chk("R10 woke", woke, 1);
    chk("R10 warm resume despite same-cycle write", resume_pulse, 1);
    chk("R10 no restart", restart_req, 0);
    write_cfg(mk(100, 0, 0, 0, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_clksel();
    t_bypass();
    t_mult();
    t_warm();
    t_cold();
    t_none();
    t_any();
    t_coincide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule